// File: doc/BRIEF.md
# Double-Buffered Barrier Waveform Player

This block plays short stored pulse shapes on several independent channels and adds them into one drive sample stream, as used to build barrier-style RF waveforms from a set of pulse generators. Each channel owns a pair of sample banks. One bank is the active bank and is read during playback. A host can rewrite the other bank at any time without disturbing the output.

The block divides its reference clock into a revolution marker, once every `DIV` cycles (588 by default). At each marker, every channel whose enable input is high begins playing its active bank from address 0, one sample per clock, and then falls silent until the next marker. A bank-swap request is held per channel and takes effect only on a marker edge. A shape change therefore never cuts a pulse off partway. Because every pending swap is applied together at one marker, a shape can be stepped at the host's update rate, for example 720 Hz.

The per-channel samples go into a sum that is wide enough never to overflow. That sum is then clamped to the signed output width.

Top module: `barrierWavePlayer`

## Requirements
- R1: `revMark` is high for exactly one clock in every `DIV` (588) clocks.
- R2: On the clock edge where `revMark` is high, each channel with `chEnable` high starts playback at address 0 of its active bank. Sample k of that playback reaches `driveOut` two clocks after address k is read, so it is visible in the cycle that begins k+2 edges after the marker edge.
- R3: A channel contributes zero while idle. After reading all `2**ADDR_W` addresses it stops, and its contribution returns to zero until a later marker.
- R4: A channel whose `chEnable` is low at a marker does not play during that revolution.
- R5: A one-cycle pulse on `swapReq[c]` is held until the next marker edge, where the active bank of channel c toggles. A pulse sampled on the marker edge itself is applied at the following marker. `activeBank[c]` shows the active bank (0 or 1). Both banks are 0 after reset.
- R6: A host write (`wrEn` with `wrCh`, `wrBank`, `wrAddr`, `wrData`) to the inactive bank of a channel is stored and does not set `writeErr`. It is heard once that bank becomes active.
- R7: A host write to a channel's active bank leaves that bank unchanged. It sets `writeErr`, which stays high until reset.
- R8: `driveOut` is the exact signed sum of all channel samples while that sum fits in `OUT_W` bits. The internal sum carries `SAMP_W + log2(NUM_CH)` bits.
- R9: A sum above `2**(OUT_W-1)-1` is output as that maximum (8191). A sum below `-2**(OUT_W-1)` is output as that minimum (-8192).
- R10: While `rstN` is low, `driveOut`, `activeBank`, `writeErr` and `revMark` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the revolution divider counts its edges |
| rstN | input | 1 | Asynchronous active-low reset |
| chEnable | input | NUM_CH | Per-channel start enable, sampled at each marker |
| swapReq | input | NUM_CH | Per-channel bank-swap request pulse |
| wrEn | input | 1 | Host write strobe |
| wrCh | input | log2(NUM_CH) | Channel index of the host write |
| wrBank | input | 1 | Bank of the host write |
| wrAddr | input | ADDR_W | Sample address of the host write |
| wrData | input | SAMP_W | Signed sample value to write |
| driveOut | output | OUT_W | Signed, saturated sum of all channels |
| revMark | output | 1 | Revolution marker, one clock wide |
| activeBank | output | NUM_CH | Active bank of each channel |
| writeErr | output | 1 | Sticky flag for a write aimed at an active bank |

## Verification
Timing is counted from the negative edge at which the bench first sees `revMark` high. The marker edge follows half a clock later. It starts address reads and applies bank swaps. One register then holds each channel sample and a second holds the clamped sum. Sample k is therefore read at the (k+3)-th falling edge after the marker was seen, and the bench compares its captured trace only at those indices. The bench samples `activeBank` at the first falling edge after the marker. It reads `writeErr` one falling edge after the write is driven, because the flag is registered.

// File: rtl/bwpPkg.sv
package bwpPkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrAccept;  // host write goes to an inactive bank
    logic wrBank;    // bank the accepted write lands in
  } bwpStrobe_t;
endpackage

// File: rtl/bwpCtrl.sv
module bwpCtrl
  import bwpPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6,
  parameter int DIV    = 588,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH-1:0]        swapReq,
  input  logic                     wrEn,
  input  logic [CH_W-1:0]          wrCh,
  input  logic                     wrBank,
  output bwpStrobe_t               strobe,
  output logic [NUM_CH-1:0]        playBank,
  output logic [NUM_CH-1:0]        playing,
  output logic [NUM_CH*ADDR_W-1:0] rdAddrFlat,
  output logic                     revMark,
  output logic                     writeErr
);
  localparam int DIV_W = $clog2(DIV);

  logic [DIV_W-1:0]  divCnt;
  logic              revTick;
  logic [NUM_CH-1:0] swapPend;
  logic [ADDR_W-1:0] rdAddr [NUM_CH];

  assign revTick = (divCnt == DIV_W'(DIV - 1));
  assign revMark = revTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (revTick) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // a write into the bank being played is refused
  assign strobe.wrAccept = wrEn && (wrBank != playBank[wrCh]);
  assign strobe.wrBank   = wrBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        writeErr <= 1'b0;
    else if (wrEn && !strobe.wrAccept) writeErr <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swapPend[ch] <= 1'b0;
        playBank[ch] <= 1'b0;
        playing[ch]  <= 1'b0;
        rdAddr[ch]   <= '0;
      end else if (revTick) begin
        playBank[ch] <= playBank[ch] ^ swapPend[ch];
        swapPend[ch] <= swapReq[ch];   // request on the marker waits a turn
        playing[ch]  <= chEnable[ch];
        rdAddr[ch]   <= '0;
      end else begin
        swapPend[ch] <= swapPend[ch] | swapReq[ch];
        if (playing[ch]) begin
          rdAddr[ch] <= rdAddr[ch] + 1'b1;
          if (rdAddr[ch] == '1) playing[ch] <= 1'b0;
        end
      end
    end
    assign rdAddrFlat[ch*ADDR_W +: ADDR_W] = rdAddr[ch];

    // R2: playback only begins on a marker edge
    assert_start_on_marker_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(playing[ch]) |-> $past(revTick));
    // R5: the active bank only changes on a marker edge
    assert_swap_on_marker_R5: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(playBank[ch]) |-> $past(revTick));
    // R3: playback ends only after the last address
    assert_stop_at_end_R3: assert property (@(posedge clk) disable iff (!rstN)
      $fell(playing[ch]) |-> ($past(rdAddr[ch]) == '1));
  end

  // R1: marker is a single-cycle pulse
  assert_marker_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    revTick |=> !revTick);
  // R7: error flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    writeErr |=> writeErr);
  // R7: a write into the active bank raises the flag
  assert_err_on_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrBank == playBank[wrCh])) |=> writeErr);
endmodule

// File: rtl/bwpDatapath.sv
module bwpDatapath
  import bwpPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6,
  parameter int SAMP_W = 12,
  parameter int OUT_W  = 14,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bwpStrobe_t               strobe,
  input  logic [CH_W-1:0]          wrCh,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic signed [SAMP_W-1:0] wrData,
  input  logic [NUM_CH-1:0]        playBank,
  input  logic [NUM_CH-1:0]        playing,
  input  logic [NUM_CH*ADDR_W-1:0] rdAddrFlat,
  output logic signed [OUT_W-1:0]  driveOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int GUARD = $clog2(NUM_CH);
  localparam int SUM_W = SAMP_W + GUARD;

  logic signed [SAMP_W-1:0] chSample [NUM_CH];
  logic signed [SUM_W-1:0]  sumWide;
  logic signed [OUT_W-1:0]  sumSat;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic signed [SAMP_W-1:0] bankMem [2][DEPTH];
    logic [ADDR_W-1:0]        rdAddr;
    assign rdAddr = rdAddrFlat[ch*ADDR_W +: ADDR_W];

    always_ff @(posedge clk) begin
      if (strobe.wrAccept && (wrCh == CH_W'(ch)))
        bankMem[strobe.wrBank][wrAddr] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            chSample[ch] <= '0;
      else if (playing[ch]) chSample[ch] <= bankMem[playBank[ch]][rdAddr];
      else                  chSample[ch] <= '0;
    end

    // R3: an idle channel contributes nothing one cycle later
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      !playing[ch] |=> (chSample[ch] == '0));
  end

  always_comb begin
    sumWide = '0;
    for (int i = 0; i < NUM_CH; i++)
      sumWide = sumWide + {{GUARD{chSample[i][SAMP_W-1]}}, chSample[i]};
  end

  if (SUM_W > OUT_W) begin : gClamp
    localparam logic signed [SUM_W-1:0] SAT_MAX = SUM_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_MIN = ~SAT_MAX;
    always_comb begin
      if (sumWide > SAT_MAX)      sumSat = SAT_MAX[OUT_W-1:0];
      else if (sumWide < SAT_MIN) sumSat = SAT_MIN[OUT_W-1:0];
      else                        sumSat = sumWide[OUT_W-1:0];
    end
  end else begin : gExtend
    assign sumSat = OUT_W'(sumWide);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveOut <= '0;
    else       driveOut <= sumSat;
  end
endmodule

// File: rtl/barrierWavePlayer.sv
module barrierWavePlayer
  import bwpPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6,
  parameter int SAMP_W = 12,
  parameter int OUT_W  = 14,
  parameter int DIV    = 588,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH-1:0]        swapReq,
  input  logic                     wrEn,
  input  logic [CH_W-1:0]          wrCh,
  input  logic                     wrBank,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic signed [SAMP_W-1:0] wrData,
  output logic signed [OUT_W-1:0]  driveOut,
  output logic                     revMark,
  output logic [NUM_CH-1:0]        activeBank,
  output logic                     writeErr
);
  bwpStrobe_t               strobe;
  logic [NUM_CH-1:0]        playing;
  logic [NUM_CH*ADDR_W-1:0] rdAddrFlat;

  bwpCtrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DIV(DIV), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .swapReq(swapReq),
    .wrEn(wrEn), .wrCh(wrCh), .wrBank(wrBank), .strobe(strobe),
    .playBank(activeBank), .playing(playing), .rdAddrFlat(rdAddrFlat),
    .revMark(revMark), .writeErr(writeErr)
  );

  bwpDatapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W),
                .OUT_W(OUT_W), .CH_W(CH_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCh(wrCh), .wrAddr(wrAddr),
    .wrData(wrData), .playBank(activeBank), .playing(playing),
    .rdAddrFlat(rdAddrFlat), .driveOut(driveOut)
  );
endmodule

// File: tb/tb_barrierWavePlayer.sv
module tb_barrierWavePlayer;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NV     = 9;
  // stimulus: value written to every channel at address k; expected summed output
  localparam int TBL_IN  [NV] = '{1, 100, 1023, 1024, -1024, -1025, 2047, -2048, -300};
  localparam int TBL_EXP [NV] = '{8, 800, 8184, 8191, -8192, -8192, 8191, -8192, -2400};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] chEnable = '0, swapReq = '0;
  logic wrEn = 1'b0, wrBank = 1'b0;
  logic [2:0] wrCh = '0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic signed [11:0] wrData = '0;
  logic signed [13:0] driveOut;
  logic revMark, writeErr;
  logic [NUM_CH-1:0] activeBank;

  int nChecks = 0, nFail = 0;
  int cap [0:DEPTH+5];
  logic [NUM_CH-1:0] bankAt1;

  always #2 clk = ~clk;

  barrierWavePlayer dut (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .swapReq(swapReq),
    .wrEn(wrEn), .wrCh(wrCh), .wrBank(wrBank), .wrAddr(wrAddr), .wrData(wrData),
    .driveOut(driveOut), .revMark(revMark), .activeBank(activeBank), .writeErr(writeErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input int ch, input int bank, input int addr, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrCh = 3'(ch); wrBank = bank[0]; wrAddr = ADDR_W'(addr); wrData = 12'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitMarker();
    do @(negedge clk); while (!revMark);
  endtask

  task automatic capture();
    waitMarker();
    for (int j = 1; j <= DEPTH + 4; j++) begin
      @(negedge clk);
      cap[j] = int'(driveOut);
      if (j == 1) bankAt1 = activeBank;
    end
  endtask

  function automatic int valFor(input int ch, input int addr);
    if (addr < NV) return TBL_IN[addr];
    if (addr == 20) return ch * 10;
    if (addr == DEPTH - 1) return 5;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int period;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 driveOut", int'(driveOut), 0);
    chk("R10 activeBank", int'(activeBank), 0);
    chk("R10 writeErr", int'(writeErr), 0);
    chk("R10 revMark", int'(revMark), 0);
    rstN = 1'b1;

    // R1 marker period
    waitMarker();
    period = 0;
    do begin @(negedge clk); period++; end while (!revMark);
    chk("R1 marker period", period, 588);

    // R6 fill inactive bank 1 of every channel
    for (int c = 0; c < NUM_CH; c++)
      for (int a = 0; a < DEPTH; a++)
        hostWrite(c, 1, a, valFor(c, a));
    chk("R6 no error on inactive write", int'(writeErr), 0);

    // R5 swap all, R2/R8/R9 playback through the table
    chEnable = '1;
    @(negedge clk);
    if (revMark) @(negedge clk);
    swapReq = '1;
    @(negedge clk);
    swapReq = '0;
    chk("R5 bank held before marker", int'(activeBank), 0);
    capture();
    chk("R5 bank toggled at marker", int'(bankAt1), 255);
    chk("R3 zero before first sample", cap[2], 0);
    for (int k = 0; k < NV; k++)
      chk($sformatf("R2 R9 table row %0d", k), cap[k+3], TBL_EXP[k]);
    chk("R8 distinct channel sum", cap[23], 280);
    chk("R3 last sample", cap[DEPTH+2], 40);
    chk("R3 zero after playback", cap[DEPTH+3], 0);

    // R7 write into active bank refused
    hostWrite(0, 1, 0, 500);
    chk("R7 error set", int'(writeErr), 1);
    capture();
    chk("R7 active bank unchanged", cap[3], 8);
    chk("R7 error sticky", int'(writeErr), 1);

    // R4 only channel 3 enabled; R6 write its inactive bank 0
    chEnable = 8'h08;
    hostWrite(3, 0, 20, 77);
    capture();
    chk("R4 single channel sample0", cap[3], 1);
    chk("R4 single channel addr20", cap[23], 30);

    // R5 request on the marker cycle is deferred a turn
    waitMarker();
    swapReq = 8'h08;
    @(negedge clk);
    swapReq = '0;
    chk("R5 request on marker deferred", int'(activeBank), 255);
    capture();
    chk("R5 deferred swap applied", int'(bankAt1), 247);
    chk("R6 new bank content played", cap[23], 77);

    // R10 reset clears state
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 writeErr cleared", int'(writeErr), 0);
    chk("R10 activeBank cleared", int'(activeBank), 0);
    chk("R10 driveOut cleared", int'(driveOut), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule